// File: doc/BRIEF.md
# Five-Level Cross-Connected Cell Gate Controller

This block drives the six gates of the high-frequency cell in one converter arm. The cell holds two stacked half-bridges, each with its own capacitor (CH1 and CH2), and a two-switch commutation leg (S1, S2) that sets the sign of the cell voltage. The cell can therefore produce five levels: plus or minus the full cell voltage Uc, plus or minus Uc/2, and zero. The controller receives the residual reference magnitude left over by the low-frequency stack, the polarity mode, the arm-current sign, the two measured capacitor voltages and a triangular carrier. From these it produces gate commands that realise the residual reference by comparing it with the carrier.

The reference magnitude is an unsigned number in which Uc equals 2^REF_W, so its top bit selects the band. In the lower band (below Uc/2), one half-bridge is held bypassed and the other is pulsed. In the upper band, one half-bridge is held inserted and the other is pulsed. The controller chooses which capacitor carries the pulses from the charge direction and from which capacitor is higher, so that the two voltages move toward each other. All decisions are sampled once per carrier period at the valley. Each complementary pair passes through a programmable dead band before it switches.

Top module: `xcell_gate_ctrl`

## Requirements
- R1: With `mode_neg` = 0 (positive polarity), S2 is on and S1 is off. With `mode_neg` = 1, S1 is on and S2 is off. The leg takes the mode latched at the most recent valley, one clock after the first compare that uses it.
- R2: Mode, reference, band and capacitor choice are latched only on a clock edge where `carrier` = 0. A change of these inputs at any other time has no effect on the gates until the next valley.
- R3: Positive-polarity codes for T1..T4: both capacitors inserted 1001; only CH2 inserted 0101; only CH1 inserted 1010; none inserted 0110.
- R4: Negative-polarity codes for T1..T4: both inserted 0110; only CH2 inserted 1010; only CH1 inserted 0101; none inserted 1001.
- R5: Lower band (reference top bit 0): the unpulsed capacitor is bypassed, and the pulsed capacitor is inserted while the latched low REF_W-1 bits exceed `carrier`.
- R6: Upper band (reference top bit 1): the unpulsed capacitor is inserted, and the pulsed capacitor is inserted while the latched low REF_W-1 bits exceed `carrier`.
- R7: In the upper band, the higher-voltage capacitor is pulsed when charging and the lower-voltage capacitor is pulsed when discharging. CH1 counts as the higher one when the two voltages are equal.
- R8: In the lower band, the lower-voltage capacitor is pulsed when charging and the higher-voltage capacitor is pulsed when discharging, with the same tie rule.
- R9: The cell is charging when `mode_neg` = 0 with `cur_pos` = 1, or when `mode_neg` = 1 with `cur_pos` = 0. The other two combinations discharge it.
- R10: When the target of a pair (T1/T2, T3/T4, S1/S2) changes, both of its switches are held off for `dead_cycles` clocks and the new state then appears. A value of 0 switches at once. A gate reaches the pins one clock after the compare that requests it.
- R11: The two switches of a pair are never on together.
- R12: During reset and after it, until the first valley takes effect, the gates read S2, T2 and T3 on and all others off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_mag | input | REF_W | Residual reference magnitude; Uc = 2^REF_W |
| mode_neg | input | 1 | Polarity mode: 0 positive, 1 negative |
| cur_pos | input | 1 | Arm current sign: 1 positive |
| vc1 | input | VC_W | Measured CH1 voltage |
| vc2 | input | VC_W | Measured CH2 voltage |
| carrier | input | REF_W-1 | Triangular carrier; 0 marks the valley |
| dead_cycles | input | DT_W | Dead band length in clocks |
| s1 | output | 1 | Commutation switch, negative polarity |
| s2 | output | 1 | Commutation switch, positive polarity |
| t1 | output | 1 | CH1 half-bridge, insert switch |
| t2 | output | 1 | CH1 half-bridge, complement |
| t3 | output | 1 | CH2 half-bridge, complement |
| t4 | output | 1 | CH2 half-bridge, insert switch |

## Verification
The bench builds the block with REF_W = 6, VC_W = 8 and DT_W = 4, and drives a 0..31..0 carrier. One carrier period therefore lasts 62 clocks, which lets many periods run through every band, mode, current sign and capacitor ordering. These sizes make both ends of the duty range reachable: a residual of 0 never pulses, and a residual of 63 pulses at every carrier value except the peak. They also allow dead bands of 0, 1 and 7 clocks to be checked against pulses only a few clocks wide. The bench changes the mode in the middle of a period to show that the change takes effect only at the next valley.

// File: rtl/xcell_pkg.sv
package xcell_pkg;

  // Gate code of the two capacitor half-bridges.
  typedef struct packed {
    logic t1;
    logic t2;
    logic t3;
    logic t4;
  } tcode_t;

  // Switch-code table indexed by polarity and the insertion state of each capacitor.
  function automatic tcode_t cell_code(input logic neg, input logic ins1, input logic ins2);
    tcode_t c;
    case ({neg, ins1, ins2})
      3'b011:  c = tcode_t'(4'b1001);
      3'b001:  c = tcode_t'(4'b0101);
      3'b010:  c = tcode_t'(4'b1010);
      3'b000:  c = tcode_t'(4'b0110);
      3'b111:  c = tcode_t'(4'b0110);
      3'b101:  c = tcode_t'(4'b1010);
      3'b110:  c = tcode_t'(4'b0101);
      default: c = tcode_t'(4'b1001);
    endcase
    return c;
  endfunction

endpackage

// File: rtl/xcell_valley_latch.sv
module xcell_valley_latch #(
  parameter int REF_W = 8,
  parameter int VC_W  = 10,
  localparam int CAR_W = REF_W - 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             valley,
  input  logic [REF_W-1:0] ref_mag,
  input  logic             mode_neg,
  input  logic             cur_pos,
  input  logic [VC_W-1:0]  vc1,
  input  logic [VC_W-1:0]  vc2,
  output logic             mode_q,
  output logic             upper_q,
  output logic [CAR_W-1:0] duty_q,
  output logic             pulse2_q
);

  logic             charge;
  logic             hi2;
  logic             upper_now;
  logic             pulse2_now;
  logic             mode_d;
  logic             upper_d;
  logic [CAR_W-1:0] duty_d;
  logic             pulse2_d;

  always_comb begin
    charge     = mode_neg ^ cur_pos;
    hi2        = (vc2 > vc1);
    upper_now  = ref_mag[REF_W-1];
    // upper+charge or lower+discharge pulse the higher cap; otherwise the lower one
    pulse2_now = hi2 ^ (upper_now ^ charge);
  end

  always_comb begin
    mode_d   = mode_q;
    upper_d  = upper_q;
    duty_d   = duty_q;
    pulse2_d = pulse2_q;
    if (valley) begin
      mode_d   = mode_neg;
      upper_d  = upper_now;
      duty_d   = ref_mag[CAR_W-1:0];
      pulse2_d = pulse2_now;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q   <= 1'b0;
      upper_q  <= 1'b0;
      duty_q   <= '0;
      pulse2_q <= 1'b0;
    end else begin
      mode_q   <= mode_d;
      upper_q  <= upper_d;
      duty_q   <= duty_d;
      pulse2_q <= pulse2_d;
    end
  end

endmodule

// File: rtl/xcell_pwm_map.sv
module xcell_pwm_map #(
  parameter int REF_W = 8,
  localparam int CAR_W = REF_W - 1
) (
  input  logic             mode_q,
  input  logic             upper_q,
  input  logic [CAR_W-1:0] duty_q,
  input  logic             pulse2_q,
  input  logic [CAR_W-1:0] carrier,
  output logic [2:0]       want
);
  import xcell_pkg::*;

  logic   pwm;
  logic   ins1;
  logic   ins2;
  tcode_t code;

  always_comb begin
    pwm  = (duty_q > carrier);
    ins1 = pulse2_q ? upper_q : pwm;
    ins2 = pulse2_q ? pwm : upper_q;
    code = cell_code(mode_q, ins1, ins2);
    // a row that is not complementary reads as first switch off
    want[0] = code.t1 & ~code.t2;
    want[1] = code.t3 & ~code.t4;
    want[2] = mode_q;
  end

endmodule

// File: rtl/xcell_deadband.sv
module xcell_deadband #(
  parameter int   DT_W   = 4,
  parameter logic RST_ON = 1'b0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            want,
  input  logic [DT_W-1:0] dead_cycles,
  output logic            g_hi,
  output logic            g_lo
);

  logic            cur_q;
  logic            cur_d;
  logic [DT_W-1:0] cnt_q;
  logic [DT_W-1:0] cnt_d;
  logic            idle;

  always_comb begin
    cur_d = want;
    cnt_d = cnt_q;
    if (want != cur_q) begin
      cnt_d = dead_cycles;
    end else if (cnt_q != '0) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q <= RST_ON;
      cnt_q <= '0;
    end else begin
      cur_q <= cur_d;
      cnt_q <= cnt_d;
    end
  end

  assign idle = (cnt_q == '0);
  assign g_hi = cur_q & idle;
  assign g_lo = ~cur_q & idle;

endmodule

// File: rtl/xcell_gate_ctrl.sv
module xcell_gate_ctrl #(
  parameter int REF_W = 8,
  parameter int VC_W  = 10,
  parameter int DT_W  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [REF_W-1:0] ref_mag,
  input  logic             mode_neg,
  input  logic             cur_pos,
  input  logic [VC_W-1:0]  vc1,
  input  logic [VC_W-1:0]  vc2,
  input  logic [REF_W-2:0] carrier,
  input  logic [DT_W-1:0]  dead_cycles,
  output logic             s1,
  output logic             s2,
  output logic             t1,
  output logic             t2,
  output logic             t3,
  output logic             t4
);

  localparam int CAR_W = REF_W - 1;
  localparam int NPAIR = 3;
  // reset: T1/T2 -> T2 on, T3/T4 -> T3 on, S1/S2 -> S2 on
  localparam logic [NPAIR-1:0] RST_PAT = 3'b010;

  logic             valley;
  logic             mode_q;
  logic             upper_q;
  logic [CAR_W-1:0] duty_q;
  logic             pulse2_q;
  logic [NPAIR-1:0] want;
  logic [NPAIR-1:0] g_hi;
  logic [NPAIR-1:0] g_lo;

  assign valley = (carrier == '0);

  xcell_valley_latch #(.REF_W(REF_W), .VC_W(VC_W)) u_latch (
    .clk      (clk),
    .rst_n    (rst_n),
    .valley   (valley),
    .ref_mag  (ref_mag),
    .mode_neg (mode_neg),
    .cur_pos  (cur_pos),
    .vc1      (vc1),
    .vc2      (vc2),
    .mode_q   (mode_q),
    .upper_q  (upper_q),
    .duty_q   (duty_q),
    .pulse2_q (pulse2_q)
  );

  xcell_pwm_map #(.REF_W(REF_W)) u_map (
    .mode_q   (mode_q),
    .upper_q  (upper_q),
    .duty_q   (duty_q),
    .pulse2_q (pulse2_q),
    .carrier  (carrier),
    .want     (want)
  );

  for (genvar gi = 0; gi < NPAIR; gi++) begin : g_pair
    xcell_deadband #(.DT_W(DT_W), .RST_ON(RST_PAT[gi])) u_db (
      .clk         (clk),
      .rst_n       (rst_n),
      .want        (want[gi]),
      .dead_cycles (dead_cycles),
      .g_hi        (g_hi[gi]),
      .g_lo        (g_lo[gi])
    );
  end

  assign t1 = g_hi[0];
  assign t2 = g_lo[0];
  assign t3 = g_hi[1];
  assign t4 = g_lo[1];
  assign s1 = g_hi[2];
  assign s2 = g_lo[2];

endmodule

// File: rtl/xcell_gate_ctrl_chk.sv
module xcell_gate_ctrl_chk #(
  parameter int REF_W = 8,
  parameter int DT_W  = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic [REF_W-2:0] carrier,
  input logic [DT_W-1:0]  dead_cycles,
  input logic             mode_q,
  input logic             s1,
  input logic             s2,
  input logic             t1,
  input logic             t2,
  input logic             t3,
  input logic             t4
);

  p_excl_t12_r11: assert property (@(posedge clk) disable iff (!rst_n) !(t1 && t2));
  p_excl_t34_r11: assert property (@(posedge clk) disable iff (!rst_n) !(t3 && t4));
  p_excl_s12_r11: assert property (@(posedge clk) disable iff (!rst_n) !(s1 && s2));

  p_dead_t1_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(t1) && $past(dead_cycles) != '0) |-> !$past(t2));
  p_dead_t3_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(t3) && $past(dead_cycles) != '0) |-> !$past(t4));
  p_dead_s1_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(s1) && $past(dead_cycles) != '0) |-> !$past(s2));

  p_hold_mode_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(carrier) != '0) |-> $stable(mode_q));

  p_leg_neg_r1: assert property (@(posedge clk) disable iff (!rst_n) s1 |-> $past(mode_q));
  p_leg_pos_r1: assert property (@(posedge clk) disable iff (!rst_n) s2 |-> !$past(mode_q));

endmodule

bind xcell_gate_ctrl xcell_gate_ctrl_chk #(.REF_W(REF_W), .DT_W(DT_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .carrier     (carrier),
  .dead_cycles (dead_cycles),
  .mode_q      (mode_q),
  .s1          (s1),
  .s2          (s2),
  .t1          (t1),
  .t2          (t2),
  .t3          (t3),
  .t4          (t4)
);

// File: tb/test_xcell_gate_ctrl.sv
`timescale 1ns/1ps
module test_xcell_gate_ctrl;
  localparam int REF_W = 6;
  localparam int VC_W  = 8;
  localparam int DT_W  = 4;
  localparam int HALF  = 32;
  localparam int PEAK  = 31;

  logic             clk = 1'b0;
  logic             rst_n;
  logic [REF_W-1:0] ref_mag;
  logic             mode_neg;
  logic             cur_pos;
  logic [VC_W-1:0]  vc1;
  logic [VC_W-1:0]  vc2;
  logic [REF_W-2:0] carrier;
  logic [DT_W-1:0]  dead_cycles;
  logic s1, s2, t1, t2, t3, t4;

  int tests = 0;
  int fails = 0;
  bit done  = 0;
  string tag = "R12";

  always #2 clk = ~clk;

  xcell_gate_ctrl #(.REF_W(REF_W), .VC_W(VC_W), .DT_W(DT_W)) i_xcell_gate_ctrl (
    .clk(clk), .rst_n(rst_n), .ref_mag(ref_mag), .mode_neg(mode_neg), .cur_pos(cur_pos),
    .vc1(vc1), .vc2(vc2), .carrier(carrier), .dead_cycles(dead_cycles),
    .s1(s1), .s2(s2), .t1(t1), .t2(t2), .t3(t3), .t4(t4)
  );

  // ---------------- behavioural reference model ----------------
  int m_mode, m_upper, m_duty, m_p2;
  int pc[3];
  int pn[3];

  // T1..T4 code from requirement R3 / R4
  function automatic logic [3:0] code_of(int neg, int c1in, int c2in);
    if (neg == 0) begin
      if (c1in && c2in) return 4'b1001;
      if (c2in)         return 4'b0101;
      if (c1in)         return 4'b1010;
      return 4'b0110;
    end else begin
      if (c1in && c2in) return 4'b0110;
      if (c2in)         return 4'b1010;
      if (c1in)         return 4'b0101;
      return 4'b1001;
    end
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mode = 0; m_upper = 0; m_duty = 0; m_p2 = 0;
      pc[0] = 0; pc[1] = 1; pc[2] = 0;
      pn[0] = 0; pn[1] = 0; pn[2] = 0;
    end else begin
      int pulsing, held, c1in, c2in;
      int w[3];
      logic [3:0] code;
      pulsing = (m_duty > int'(carrier)) ? 1 : 0;
      held    = m_upper;
      if (m_p2 != 0) begin c1in = held; c2in = pulsing; end
      else           begin c1in = pulsing; c2in = held; end
      code = code_of(m_mode, c1in, c2in);
      w[0] = code[3];
      w[1] = code[1];
      w[2] = m_mode;
      for (int k = 0; k < 3; k++) begin
        if (w[k] != pc[k]) begin pc[k] = w[k]; pn[k] = int'(dead_cycles); end
        else if (pn[k] > 0) pn[k] = pn[k] - 1;
      end
      if (carrier == 0) begin
        int charging, c2_higher;
        m_mode  = mode_neg;
        m_upper = (int'(ref_mag) >= HALF) ? 1 : 0;
        m_duty  = m_upper ? int'(ref_mag) - HALF : int'(ref_mag);
        charging  = ((mode_neg == 0 && cur_pos == 1) || (mode_neg == 1 && cur_pos == 0)) ? 1 : 0;
        c2_higher = (vc2 > vc1) ? 1 : 0;
        if (m_upper) m_p2 = charging ? c2_higher : !c2_higher;
        else         m_p2 = charging ? !c2_higher : c2_higher;
      end
    end
  end

  function automatic logic [5:0] expected();
    logic [5:0] e;
    e[5] = (pc[2] == 1 && pn[2] == 0);
    e[4] = (pc[2] == 0 && pn[2] == 0);
    e[3] = (pc[0] == 1 && pn[0] == 0);
    e[2] = (pc[0] == 0 && pn[0] == 0);
    e[1] = (pc[1] == 1 && pn[1] == 0);
    e[0] = (pc[1] == 0 && pn[1] == 0);
    return e;
  endfunction

  task automatic compare();
    logic [5:0] got, exp;
    got = {s1, s2, t1, t2, t3, t4};
    exp = expected();
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s gates {s1,s2,t1..t4} got %b expected %b at %0t", tag, got, exp, $time);
    end
    tests++;
    if ((s1 && s2) || (t1 && t2) || (t3 && t4)) begin
      fails++;
      $display("FAIL R11 pair overlap got %b expected no pair 11 at %0t", got, $time);
    end
  endtask

  int car = 0;
  bit up  = 1;

  task automatic run(int cycles);
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      compare();
      if (up) begin car++; if (car == PEAK) up = 0; end
      else    begin car--; if (car == 0) up = 1; end
      carrier = car[REF_W-2:0];
    end
  endtask

  initial begin
    rst_n = 0; ref_mag = 0; mode_neg = 0; cur_pos = 1;
    vc1 = 100; vc2 = 100; carrier = 0; dead_cycles = 2;
    repeat (3) @(negedge clk);
    tag = "R12 reset state";
    tests++;
    if ({s1, s2, t1, t2, t3, t4} !== 6'b010110) begin
      fails++;
      $display("FAIL R12 reset got %b expected 010110", {s1, s2, t1, t2, t3, t4});
    end
    rst_n = 1;
    run(10);
    tag = "R5 R3 lower band, positive"; ref_mag = 10; run(130);
    tag = "R6 R3 upper band, positive"; ref_mag = 50; run(130);
    tag = "R7 upper charge, CH2 higher"; vc2 = 120; run(130);
    tag = "R7 upper discharge R9"; cur_pos = 0; run(130);
    tag = "R8 lower discharge"; ref_mag = 20; run(130);
    tag = "R8 lower charge, CH1 higher"; cur_pos = 1; vc1 = 130; run(130);
    tag = "R1 R4 negative mode, lower"; mode_neg = 1; cur_pos = 0; run(130);
    tag = "R4 R9 negative upper discharge"; ref_mag = 45; cur_pos = 1; run(130);
    tag = "R7 tie rule"; vc1 = 90; vc2 = 90; cur_pos = 0; run(130);
    tag = "R5 zero residual"; ref_mag = 0; run(130);
    tag = "R6 full residual"; ref_mag = 63; run(130);
    tag = "R2 mid-period mode change"; run(20); mode_neg = 0; ref_mag = 5; run(20);
    mode_neg = 1; run(100);
    tag = "R10 zero dead band"; dead_cycles = 0; mode_neg = 0; ref_mag = 40; run(130);
    tag = "R10 one-clock dead band"; dead_cycles = 1; ref_mag = 12; run(130);
    tag = "R10 seven-clock dead band"; dead_cycles = 7; mode_neg = 1; ref_mag = 35; run(130);
    tag = "R1 back to positive"; mode_neg = 0; run(130);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired in phase %s", tag);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule